// File: doc/BRIEF.md
# Receive Collision Frame Filter

This block sits on the receive path between the byte deserialiser and the write port of the receive FIFO. Every received byte arrives with a valid strobe, optional start-of-frame and end-of-frame marks, and a collision indication. The block forwards the bytes of a frame to the FIFO and makes one final decision for the frame at its last byte. It either commands the FIFO to throw the frame away or it emits a frame status word. The status word carries a collision flag and the total received length.

The slot boundary is 64 bytes, counted from the first byte of the frame. A collision that starts before this boundary normally makes the frame vanish from the FIFO with no status, so the host never sees it. A collision at or after the boundary is a late collision. The data written to the FIFO is cut off at the point of collision, but the frame is kept and reported. A frame shorter than 64 bytes is a runt. Two configuration bits change the outcome: one keeps frames that collided early, and one accepts runts that did not collide.

Top module: `rx_coll_filter`

## Requirements
- R1: While and directly after a synchronous reset, fifo_wr, fifo_drop and stat_vld are 0.
- R2: Each valid byte from the byte marked start-of-frame through the byte marked end-of-frame is written to the FIFO (fifo_wr=1, fifo_data equal to the byte) one cycle after it is presented, in order. A valid byte outside a frame is never written. A start-of-frame byte always opens a new frame.
- R3: The byte presented with in_coll=1 is not written, and neither is any later byte of the same frame. in_coll has no effect on a cycle where in_vld=0.
- R4: With cfg_low_lat=0, a frame of at least 64 bytes whose collision starts at byte index 0..63 (first byte = index 0) is discarded. fifo_drop pulses once, one cycle after the end-of-frame byte, and no status is emitted.
- R5: With cfg_low_lat=1, a frame of at least 64 bytes that collided at index 0..63 is kept. Its status has stat_coll=1.
- R6: A frame of fewer than 64 bytes that collided is always discarded, whatever cfg_low_lat and cfg_runt_acc hold.
- R7: A collision-free frame of fewer than 64 bytes is discarded when cfg_runt_acc=0. When cfg_runt_acc=1 it is kept with stat_coll=0.
- R8: A frame whose collision starts at index 64 or later is kept. Its status has stat_coll=1. A collision-free frame of 64 or more bytes is kept with stat_coll=0.
- R9: For a kept frame, stat_len is the total number of valid bytes of the frame, including bytes after the collision. It saturates at 2^CNT_W-1 (2047 by default) and is never 0.
- R10: For every frame, exactly one of fifo_drop or stat_vld pulses, one cycle after the end-of-frame byte, and never both at once. Both configuration bits are taken from the cycle of the end-of-frame byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Received byte valid |
| in_data | input | DATA_W | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_coll | input | 1 | Collision detected on this byte |
| cfg_low_lat | input | 1 | Keep frames with an early collision |
| cfg_runt_acc | input | 1 | Accept collision-free runts |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | FIFO write data |
| fifo_drop | output | 1 | Discard the frame being written |
| stat_vld | output | 1 | Frame status valid |
| stat_coll | output | 1 | Frame suffered a collision |
| stat_len | output | CNT_W | Total received byte count |

## Verification
Every output is registered once. The write for a byte, and the drop or status for an end-of-frame byte, therefore show up one clock after the edge that samples that byte. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares the model with the ports at the next falling edge, so each comparison falls on the one cycle where the result is due. The frames put the collision at index 63 and at index 64, use runts of 1 and 63 bytes, insert idle gaps that carry a stray collision flag, send bytes outside any frame, and send a frame long enough to saturate the count.

// File: rtl/rx_coll_filter_pkg.sv
package rx_coll_filter_pkg;

  typedef struct packed {
    logic drop;
    logic keep;
    logic coll;
  } verdict_t;

endpackage

// File: rtl/rx_coll_filter_track.sv
module rx_coll_filter_track #(
  parameter int CNT_W      = 11,
  parameter int SLOT_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             sof,
  input  logic             eof,
  input  logic             coll,
  output logic             take,
  output logic             wr_ok,
  output logic             last,
  output logic [CNT_W-1:0] total,
  output logic             coll_any,
  output logic             coll_early
);
  localparam logic [CNT_W-1:0] MAXC   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(SLOT_BYTES);

  logic             active_q;
  logic             seen_q;
  logic             early_q;
  logic [CNT_W-1:0] cnt_q;

  logic [CNT_W-1:0] idx;
  logic             seen_eff;

  always_comb begin
    take       = vld && (active_q || sof);
    idx        = sof ? '0 : cnt_q;
    seen_eff   = !sof && seen_q;
    coll_any   = seen_eff || coll;
    coll_early = seen_eff ? early_q : (coll && (idx < SLOT_C));
    total      = (idx == MAXC) ? MAXC : idx + CNT_W'(1);
    wr_ok      = take && !coll_any;
    last       = take && eof;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      seen_q   <= 1'b0;
      early_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (take) begin
      active_q <= !eof;
      seen_q   <= coll_any;
      early_q  <= coll_early;
      cnt_q    <= total;
    end
  end
endmodule

// File: rtl/rx_coll_filter_judge.sv
module rx_coll_filter_judge
  import rx_coll_filter_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int SLOT_BYTES = 64
) (
  input  logic             last,
  input  logic [CNT_W-1:0] total,
  input  logic             coll_any,
  input  logic             coll_early,
  input  logic             low_lat,
  input  logic             runt_acc,
  output verdict_t         verdict
);
  localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(SLOT_BYTES);

  logic runt;
  logic kill;

  always_comb begin
    runt = total < SLOT_C;
    if (runt) kill = coll_any || !runt_acc;
    else      kill = coll_early && !low_lat;
    verdict.drop = last && kill;
    verdict.keep = last && !kill;
    verdict.coll = coll_any;
  end
endmodule

// File: rtl/rx_coll_filter.sv
module rx_coll_filter
  import rx_coll_filter_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 11,
  parameter int SLOT_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_coll,
  input  logic              cfg_low_lat,
  input  logic              cfg_runt_acc,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_drop,
  output logic              stat_vld,
  output logic              stat_coll,
  output logic [CNT_W-1:0]  stat_len
);
  logic             take;
  logic             wr_ok;
  logic             last;
  logic [CNT_W-1:0] total;
  logic             coll_any;
  logic             coll_early;
  verdict_t         verdict;

  rx_coll_filter_track #(.CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES)) track_i (
    .clk(clk), .rst(rst), .vld(in_vld), .sof(in_sof), .eof(in_eof),
    .coll(in_coll), .take(take), .wr_ok(wr_ok), .last(last), .total(total),
    .coll_any(coll_any), .coll_early(coll_early)
  );

  rx_coll_filter_judge #(.CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES)) judge_i (
    .last(last), .total(total), .coll_any(coll_any), .coll_early(coll_early),
    .low_lat(cfg_low_lat), .runt_acc(cfg_runt_acc), .verdict(verdict)
  );

  // single register stage on every output
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
      fifo_drop <= 1'b0;
      stat_vld  <= 1'b0;
      stat_coll <= 1'b0;
      stat_len  <= '0;
    end else begin
      fifo_wr   <= wr_ok;
      fifo_drop <= verdict.drop;
      stat_vld  <= verdict.keep;
      if (take) fifo_data <= in_data;
      if (verdict.keep) begin
        stat_coll <= verdict.coll;
        stat_len  <= total;
      end
    end
  end
endmodule

// File: rtl/rx_coll_filter_chk.sv
module rx_coll_filter_chk #(
  parameter int CNT_W      = 11,
  parameter int SLOT_BYTES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             in_eof,
  input logic             in_coll,
  input logic             fifo_wr,
  input logic             fifo_drop,
  input logic             stat_vld,
  input logic             stat_coll,
  input logic [CNT_W-1:0] stat_len
);
  localparam logic [CNT_W-1:0] SLOT_C = CNT_W'(SLOT_BYTES);

  p_trunc_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_coll) |=> !fifo_wr);

  p_one_verdict_r10: assert property (@(posedge clk) disable iff (rst)
    !(fifo_drop && stat_vld));

  p_verdict_time_r10: assert property (@(posedge clk) disable iff (rst)
    (fifo_drop || stat_vld) |-> $past(in_vld && in_eof));

  p_runt_coll_gone_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_vld && (stat_len < SLOT_C)) |-> !stat_coll);

  p_len_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    stat_vld |-> (stat_len != '0));
endmodule

bind rx_coll_filter rx_coll_filter_chk #(.CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES)) chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_eof(in_eof), .in_coll(in_coll),
  .fifo_wr(fifo_wr), .fifo_drop(fifo_drop), .stat_vld(stat_vld),
  .stat_coll(stat_coll), .stat_len(stat_len)
);

// File: tb/rx_coll_filter_tb_top.sv
module rx_coll_filter_tb_top;
  localparam int DW   = 8;
  localparam int CW   = 11;
  localparam int SLOT = 64;
  localparam int MAXC = 2047;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_coll = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          cfg_low_lat = 1'b0, cfg_runt_acc = 1'b0;
  logic          fifo_wr, fifo_drop, stat_vld, stat_coll;
  logic [DW-1:0] fifo_data;
  logic [CW-1:0] stat_len;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0, cmp_on = 0;

  rx_coll_filter #(.DATA_W(DW), .CNT_W(CW), .SLOT_BYTES(SLOT)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_coll(in_coll), .cfg_low_lat(cfg_low_lat),
    .cfg_runt_acc(cfg_runt_acc), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .fifo_drop(fifo_drop), .stat_vld(stat_vld), .stat_coll(stat_coll),
    .stat_len(stat_len)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // behavioural reference model
  int    m_cnt, idx, tot;
  bit    m_act, m_coll, m_early, prior, cnow, early;
  bit    e_wr, e_drop, e_stat, e_coll;
  int    e_data, e_len;
  string e_tag = "R10", w_tag = "R2";

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      check(1'b0, "R10", "watchdog", cyc, 150000);
      finish_run();
    end
    if (rst) begin
      m_act = 0; m_cnt = 0; m_coll = 0; m_early = 0;
      e_wr = 0; e_drop = 0; e_stat = 0;
    end else begin
      e_wr = 0; e_drop = 0; e_stat = 0; w_tag = "R2";
      if (in_vld && (m_act || in_sof)) begin
        idx   = in_sof ? 0 : m_cnt;
        prior = !in_sof && m_coll;
        cnow  = prior || in_coll;
        early = prior ? m_early : (in_coll && idx < SLOT);
        tot   = (idx + 1 > MAXC) ? MAXC : idx + 1;
        e_wr  = !cnow;
        e_data = int'(in_data);
        w_tag = cnow ? "R3" : "R2";
        if (in_eof) begin
          e_len = tot; e_coll = cnow;
          if (tot < SLOT && cnow)        begin e_drop = 1; e_tag = "R6"; end
          else if (tot < SLOT)           begin
            e_tag = "R7";
            if (cfg_runt_acc) e_stat = 1; else e_drop = 1;
          end
          else if (early && !cfg_low_lat) begin e_drop = 1; e_tag = "R4"; end
          else if (early)                begin e_stat = 1; e_tag = "R5"; end
          else                           begin e_stat = 1; e_tag = cnow ? "R8" : "R2"; end
        end
        m_act = !in_eof; m_cnt = tot; m_coll = cnow; m_early = early;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(fifo_wr == e_wr, w_tag, "fifo_wr", int'(fifo_wr), int'(e_wr));
      if (e_wr) check(int'(fifo_data) == e_data, "R2", "fifo_data", int'(fifo_data), e_data);
      check(fifo_drop == e_drop, e_tag, "fifo_drop", int'(fifo_drop), int'(e_drop));
      check(stat_vld == e_stat, e_tag, "stat_vld", int'(stat_vld), int'(e_stat));
      if (e_stat && stat_vld) begin
        check(stat_coll == e_coll, e_tag, "stat_coll", int'(stat_coll), int'(e_coll));
        check(int'(stat_len) == e_len, "R9", "stat_len", int'(stat_len), e_len);
      end
      check(!(fifo_drop && stat_vld), "R10", "drop_and_status", 1, 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = 0; in_sof = 0; in_eof = 0; in_coll = 0;
    end
  endtask

  // coll_at < 0 means no collision; gaps inserts idle cycles with stray in_coll
  task automatic frame(input int len, input int coll_at, input bit ll,
                       input bit ra, input bit gaps);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cfg_low_lat = ll; cfg_runt_acc = ra;
      in_vld = 1; in_data = DW'(i * 7 + len);
      in_sof = (i == 0); in_eof = (i == len - 1); in_coll = (i == coll_at);
      if (gaps && (i % 7 == 3) && i != len - 1) begin
        @(negedge clk);
        in_vld = 0; in_sof = 0; in_eof = 0; in_coll = 1;
      end
    end
    idle(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fifo_wr == 0 && fifo_drop == 0 && stat_vld == 0, "R1", "reset_outputs",
          int'(fifo_wr) + int'(fifo_drop) + int'(stat_vld), 0);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    check(fifo_wr == 0 && fifo_drop == 0 && stat_vld == 0, "R1", "after_reset",
          int'(fifo_wr) + int'(fifo_drop) + int'(stat_vld), 0);
    // stray bytes with no frame open (R2) and a collision on them (R3)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_vld = 1; in_data = DW'(i); in_coll = (i == 2);
    end
    idle(2);
    frame(70, -1, 0, 0, 0);    // R2/R8 clean long frame
    frame(64, -1, 0, 0, 1);    // exact slot, gaps with stray collision (R3)
    frame(63, -1, 0, 0, 0);    // R7 runt dropped
    frame(63, -1, 0, 1, 0);    // R7 runt accepted
    frame(1, -1, 0, 1, 0);     // single byte runt accepted
    frame(1, -1, 0, 0, 0);     // single byte runt dropped
    frame(100, 10, 0, 0, 0);   // R4 early collision dropped
    frame(100, 10, 1, 0, 1);   // R5 kept with low latency
    frame(100, 63, 0, 0, 0);   // R4 boundary, last early index
    frame(100, 64, 0, 0, 0);   // R8 first late index
    frame(120, 80, 0, 0, 1);   // R8 late, gaps
    frame(20, 5, 1, 1, 0);     // R6 runt collision always dropped
    frame(63, 62, 1, 1, 0);    // R6 boundary
    frame(64, 0, 1, 0, 0);     // R5 collision on first byte
    frame(2100, -1, 0, 0, 0);  // R9 saturation
    frame(2100, 1500, 0, 0, 0);// R9 saturation with late collision
    // new start-of-frame opens a fresh frame (R2)
    frame(30, -1, 0, 0, 0);
    frame(66, -1, 0, 0, 0);
    idle(4);
    finish_run();
  end
endmodule